// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 32-bit program counter of a simple load/store processor core and chooses its value for the next cycle. Each cycle it takes the fetched instruction word, a register operand for indirect jumps and an equality flag from an outside comparator. It decodes the opcode and function fields itself and picks one of four next addresses: the sequential address, a PC-relative branch target, a region-absolute jump target, or a register-held target.

Call instructions also produce a link value, the address of the following instruction, along with a write request for register 31. A stall input freezes the counter and blocks the link write for that cycle. The register file, instruction memory and comparator sit outside this block.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous reset (rstN low at a clock edge) loads the PC with 0x00400000.
- R2: When no other rule applies (any opcode other than 2, 3, 4, 5, or opcode 0 with a function other than 8), the PC advances by 4.
- R3: Opcode 4 with eqFlag=1, or opcode 5 with eqFlag=0, loads PC+4 plus (sign-extended instr[15:0] shifted left by 2). Negative offsets wrap modulo 2^32.
- R4: Opcode 4 with eqFlag=0, or opcode 5 with eqFlag=1, advances by 4.
- R5: Opcodes 2 and 3 load {PC+4[31:28], instr[25:0], 2'b00}.
- R6: Opcode 0 with function instr[5:0]=8 loads regVal.
- R7: For opcode 3, linkWe is 1 and linkData equals PC+4 in the same cycle. For any other opcode, linkWe is 0.
- R8: While stall is 1, the PC holds its value and linkWe is 0.
- R9: pcOut always shows the current PC register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Hold PC and block link write |
| instr | input | 32 | Fetched instruction |
| regVal | input | 32 | Source register value for indirect jump |
| eqFlag | input | 1 | Compared registers equal |
| pcOut | output | 32 | Current PC |
| linkWe | output | 1 | Write request for register 31 |
| linkAddr | output | 5 | Link register index (31) |
| linkData | output | 32 | Return address, PC+4 |

## Verification
The hardest cases to reach are the far edges of the address arithmetic: the most negative branch offset, which wraps below zero, and a jump taken from near the top of a 256 MB region, where the upper PC bits come from PC+4 rather than from PC. The bench reaches them by using a register-indirect jump to put the PC at a chosen address such as 0x0FFFFFFC or 0x00000000. It then issues the branch or jump from there and compares every cycle against a behavioural model.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;
  localparam int XLEN = 32;
  localparam int OPW = 6;
  localparam logic [XLEN-1:0] RESET_VEC = 32'h0040_0000;
  localparam logic [OPW-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OPW-1:0] OP_JUMP = 6'd2;
  localparam logic [OPW-1:0] OP_CALL = 6'd3;
  localparam logic [OPW-1:0] OP_BREQ = 6'd4;
  localparam logic [OPW-1:0] OP_BRNE = 6'd5;
  localparam logic [5:0] FN_JREG = 6'd8;
  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [1:0] {SEL_SEQ, SEL_BRANCH, SEL_JUMP, SEL_REG} nextSel_e;

  typedef struct packed {
    nextSel_e sel;
    logic     load;
    logic     link;
  } pcCtrl_t;
endpackage

// File: rtl/pc_next_ctrl.sv
module pc_next_ctrl
  import pc_next_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        eqFlag,
  input  logic        stall,
  output pcCtrl_t     ctrl
);
  logic [OPW-1:0] opcode;
  logic [5:0]     funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    ctrl.sel  = SEL_SEQ;
    ctrl.load = ~stall;
    ctrl.link = 1'b0;
    unique case (opcode)
      OP_JUMP: ctrl.sel = SEL_JUMP;
      OP_CALL: begin
        ctrl.sel  = SEL_JUMP;
        ctrl.link = ~stall;
      end
      OP_BREQ: if (eqFlag) ctrl.sel = SEL_BRANCH;
      OP_BRNE: if (!eqFlag) ctrl.sel = SEL_BRANCH;
      OP_SPECIAL: if (funct == FN_JREG) ctrl.sel = SEL_REG;
      default: ctrl.sel = SEL_SEQ;
    endcase
  end
endmodule

// File: rtl/pc_next_dp.sv
module pc_next_dp
  import pc_next_pkg::*;
#(
  parameter int W = XLEN,
  parameter logic [W-1:0] RST_PC = RESET_VEC
) (
  input  logic         clk,
  input  logic         rstN,
  input  pcCtrl_t      ctrl,
  input  logic [31:0]  instr,
  input  logic [W-1:0] regVal,
  output logic [W-1:0] pc,
  output logic [W-1:0] pcPlus4
);
  localparam int OFFW = 16;
  localparam int JW = 26;
  localparam int HIW = W - JW - 2;

  logic [W-1:0] branchTgt, jumpTgt, nextPc;
  logic [W-1:0] offExt;

  assign pcPlus4   = pc + W'(4);
  assign offExt    = {{(W-OFFW-2){instr[OFFW-1]}}, instr[OFFW-1:0], 2'b00};
  assign branchTgt = pcPlus4 + offExt;
  assign jumpTgt   = {pcPlus4[W-1 -: HIW], instr[JW-1:0], 2'b00};

  always_comb begin
    unique case (ctrl.sel)
      SEL_BRANCH: nextPc = branchTgt;
      SEL_JUMP:   nextPc = jumpTgt;
      SEL_REG:    nextPc = regVal;
      default:    nextPc = pcPlus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pc <= RST_PC;
    else if (ctrl.load) pc <= nextPc;
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic [31:0] regVal,
  input  logic        eqFlag,
  output logic [31:0] pcOut,
  output logic        linkWe,
  output logic [4:0]  linkAddr,
  output logic [31:0] linkData
);
  pcCtrl_t ctrl;
  logic [31:0] pcPlus4;

  pc_next_ctrl u_ctrl (
    .instr(instr), .eqFlag(eqFlag), .stall(stall), .ctrl(ctrl)
  );

  pc_next_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .instr(instr), .regVal(regVal),
    .pc(pcOut), .pcPlus4(pcPlus4)
  );

  assign linkWe   = ctrl.link & rstN;
  assign linkAddr = LINK_REG;
  assign linkData = pcPlus4;
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stall,
  input logic [31:0] instr,
  input logic [31:0] regVal,
  input logic        eqFlag,
  input logic [31:0] pcOut,
  input logic        linkWe,
  input logic [31:0] linkData
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  logic [5:0] op;
  assign op = instr[31:26];

  assert_reset_vec_R1: assert property (@(posedge clk) disable iff (!started)
    !rstN |=> pcOut == 32'h0040_0000);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(pcOut));

  assert_stall_nolink_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !linkWe);

  assert_link_only_call_R7: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (op == 6'd3 && linkData == pcOut + 32'd4));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && (op == 6'd8 || op == 6'd35)) |=> pcOut == $past(pcOut) + 32'd4);

  assert_reg_jump_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && op == 6'd0 && instr[5:0] == 6'd8) |=> pcOut == $past(regVal));

  assert_notaken_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && op == 6'd4 && !eqFlag) |=> pcOut == $past(pcOut) + 32'd4);
endmodule

bind pc_next_unit pc_next_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .instr(instr), .regVal(regVal),
  .eqFlag(eqFlag), .pcOut(pcOut), .linkWe(linkWe), .linkData(linkData)
);

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0, stall = 1'b0, eqFlag = 1'b0;
  logic [31:0] instr = 32'h0, regVal = 32'h0;
  logic [31:0] pcOut, linkData;
  logic linkWe;
  logic [4:0] linkAddr;

  int nChecks = 0, nFails = 0;
  logic [31:0] modelPc;

  always #2 clk = ~clk;

  pc_next_unit u0 (
    .clk(clk), .rstN(rstN), .stall(stall), .instr(instr), .regVal(regVal),
    .eqFlag(eqFlag), .pcOut(pcOut), .linkWe(linkWe), .linkAddr(linkAddr),
    .linkData(linkData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelNext(input logic [31:0] pc, input logic [31:0] ins,
                                           input logic [31:0] rv, input logic eq);
    int op = int'(ins[31:26]);
    logic [31:0] p4 = pc + 32'd4;
    logic [31:0] off = {{14{ins[15]}}, ins[15:0], 2'b00};
    if (op == 2 || op == 3) return {p4[31:28], ins[25:0], 2'b00};
    if ((op == 4 && eq) || (op == 5 && !eq)) return p4 + off;
    if (op == 0 && ins[5:0] == 6'd8) return rv;
    return p4;
  endfunction

  // one cycle: drive, check combinational link outputs, clock, check PC
  task automatic step(input string req, input logic [31:0] ins, input logic [31:0] rv,
                      input logic eq, input logic st);
    logic expWe;
    instr = ins; regVal = rv; eqFlag = eq; stall = st;
    #1;
    expWe = (ins[31:26] == 6'd3) && !st;
    check({req, " R7 linkWe"}, {31'd0, linkWe}, {31'd0, expWe});
    if (expWe) begin
      check({req, " R7 linkData"}, linkData, modelPc + 32'd4);
      check({req, " R7 linkAddr"}, {27'd0, linkAddr}, 32'd31);
    end
    if (!st) modelPc = modelNext(modelPc, ins, rv, eq);
    @(posedge clk); #1;
    check({req, " R9 pc"}, pcOut, modelPc);
  endtask

  initial begin
    #400000;
    nFails++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    @(posedge clk); #1;
    modelPc = 32'h0040_0000;
    check("R1 reset", pcOut, 32'h0040_0000);
    rstN = 1'b1;
    // R2 sequential with assorted opcodes
    step("R2 slt", 32'h0085_402A, 0, 0, 0);
    step("R2 addi", 32'h20A5_0004, 0, 0, 0);
    step("R2 lw", 32'h8C00_0000, 0, 1, 0);
    // reach 0x00400020 then beq at 0x24 offset 2 -> 0x30
    step("R6 jr", 32'h0100_0008, 32'h0040_0020, 0, 0);
    check("R6 jr target", pcOut, 32'h0040_0020);
    step("R2 slt", 32'h0085_402A, 0, 0, 0);
    step("R3 beq taken", 32'h1100_0002, 0, 1, 0);
    check("R3 beq example", pcOut, 32'h0040_0030);
    step("R4 beq not taken", 32'h1100_0002, 0, 0, 0);
    step("R4 bne not taken", 32'h1500_0010, 0, 1, 0);
    step("R3 bne taken", 32'h1500_0010, 0, 0, 0);
    step("R3 bne negative", 32'h1500_FFF0, 0, 0, 0);
    step("R5 j 2500", 32'h0800_09C4, 0, 0, 0);
    check("R5 j 2500 -> 10000", pcOut, 32'd10000);
    step("R5 R7 jal", 32'h0C10_0008, 0, 0, 0);
    step("R8 stall jal", 32'h0C00_0100, 0, 0, 1);
    step("R8 stall beq", 32'h1000_0040, 0, 1, 1);
    step("R6 jr funct mismatch R2", 32'h0100_0009, 32'h1234_0000, 0, 0);
    // region edge: PC+4 crosses into next 256MB region
    step("R6 jr", 32'h0100_0008, 32'h0FFF_FFFC, 0, 0);
    step("R5 region edge", 32'h0800_0004, 0, 0, 0);
    check("R5 upper bits from PC+4", pcOut, 32'h1000_0010);
    // wrap below zero
    step("R6 jr", 32'h0100_0008, 32'h0000_0000, 0, 0);
    step("R3 wrap most negative", 32'h1000_8000, 0, 1, 0);
    check("R3 wrap value", pcOut, 32'hFFFE_0004);
    step("R7 jal near top", 32'h0C00_0001, 0, 1, 0);
    // reset mid-run
    rstN = 1'b0; instr = 32'h0800_0123; #1;
    check("R7 no link in reset", {31'd0, linkWe}, 32'd0);
    @(posedge clk); #1;
    modelPc = 32'h0040_0000;
    check("R1 reset mid-run", pcOut, 32'h0040_0000);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++)
      step("R2 loop", 32'h0000_0020 | (i << 11), 0, i[0], 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule